// File: doc/BRIEF.md
# Bit-Interleaved Justification Frame Multiplexer

This block combines four tributary streams, already brought to a common adapted rate, into one aggregate serial stream running at four times that rate. Each clock cycle it emits one aggregate bit. Data bits are taken from the tributaries in strict rotation: tributary 0, then 1, then 2, then 3, and then the rotation starts again. Four adapted streams at 2.112 Mbit/s would therefore give an 8.448 Mbit/s aggregate.

A frame position counter runs over an 848-bit frame. At fixed positions it replaces tributary data with overhead. The frame opens with a 10-bit alignment word and two service bits. Three control groups follow, placed at the starts of the second, third and fourth quarters of the frame. In each group every tributary sends its justification flag once, so a receiver can take a majority vote over the three copies. Right after the last control group comes one stuffable slot per tributary. In that slot a stuffed tributary sends a filler 1. A tributary that is not stuffed sends a data bit there.

The stuff decision is made outside the block. It arrives as one flag per tributary and is sampled once per frame. The block pulls data from each tributary adapter with a per-tributary read-enable. The enable is raised only in the cycles where that tributary's bit is placed into the frame.

Top module: `bitjust_mux`

## Requirements
- R1: Frame position p runs from 0 to 847 and advances by one each clock cycle, wrapping to 0. Every data-bearing position belongs to tributary p mod 4.
- R2: Positions 0 to 9 carry the alignment word 1111010000, sent from left to right, so position 0 carries the leftmost 1.
- R3: Positions 10 and 11 are service bits and always carry 1.
- R4: Positions 212+t, 424+t and 636+t, for tributary t from 0 to 3, carry that tributary's latched stuff flag, where 1 means stuffed in this frame.
- R5: Position 640+t is tributary t's stuffable slot. If the latched flag is 1, the slot carries a filler 1 and readEn[t] stays low. If the flag is 0, the slot carries a data bit and readEn[t] is high.
- R6: stuffReq is sampled in the cycle in which the frame position is 0. The sampled value governs all control and stuffable slots of that frame, and changes to stuffReq at any other time have no effect.
- R7: readEn[t] is high only in cycles where position p is a data-bearing slot for tributary t. At most one readEn bit is high in any cycle.
- R8: serOut is registered. In the cycle after readEn[t] is high it carries the value tribData[t] had in the cycle readEn[t] was high. In the cycle after an overhead position it carries that position's overhead bit.
- R9: frameStart is high exactly in the cycles where serOut carries position 0 of a frame, once every 848 cycles.
- R10: While rstN is low, serOut, frameStart and readEn are all 0, and the first cycle after reset is position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Aggregate bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| tribData | input | 4 | Current bit offered by each tributary adapter |
| stuffReq | input | 4 | Per-tributary stuff request, sampled at frame position 0 |
| readEn | output | 4 | Per-tributary pull strobe, one-hot or zero |
| serOut | output | 1 | Aggregate serial output |
| frameStart | output | 1 | Marks the first bit of each frame on serOut |

## Verification
A wrong frame position shows up first as a misplaced alignment bit or a misplaced readEn strobe. Either one appears within a single frame, so at most 848 cycles later. A wrong latched stuff flag shows in the very next control group, and it shows again as a filler or data mismatch at the stuffable slot of that same frame. The reference model compares readEn in every cycle and serOut in every cycle, so an error shows at the ports in the cycle it happens or one cycle later.

// File: rtl/bitjust_pkg.sv
package bitjust_pkg;

  typedef struct packed {
    logic       takeData;   // slot is data-bearing for tribSel
    logic [1:0] tribSel;    // interleave position of the current slot
    logic       ovBit;      // overhead value when takeData is low
    logic       frameHead;  // current slot is frame position 0
  } slotStrobe_t;

endpackage

// File: rtl/bitjust_ctrl.sv
module bitjust_ctrl
  import bitjust_pkg::*;
#(
  parameter int NUM_TRIB  = 4,
  parameter int FRAME_LEN = 848,
  parameter int FAW_LEN   = 10,
  parameter logic [FAW_LEN-1:0] FAW_WORD = 10'b1111010000,
  parameter int SVC_LEN   = 2,
  parameter int JC_REPEAT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIB-1:0] stuffReq,
  output slotStrobe_t         strobe
);
  localparam int PW      = $clog2(FRAME_LEN);
  localparam int SUB_LEN = FRAME_LEN / (JC_REPEAT + 1);
  localparam int STUFF_AT = JC_REPEAT * SUB_LEN + NUM_TRIB;

  logic [PW-1:0]       pos;
  logic [NUM_TRIB-1:0] stuffLatch;
  int unsigned         posI;
  logic [1:0]          tribIdx;
  logic                inJc;

  assign posI    = 32'(pos);
  assign tribIdx = 2'(posI % NUM_TRIB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos        <= '0;
      stuffLatch <= '0;
    end else begin
      if (posI == FRAME_LEN - 1) pos <= '0;
      else                       pos <= pos + 1'b1;
      if (posI == 0) stuffLatch <= stuffReq;
    end
  end

  always_comb begin
    inJc = 1'b0;
    for (int k = 1; k <= JC_REPEAT; k++) begin
      if (posI >= 32'(k * SUB_LEN) && posI < 32'(k * SUB_LEN + NUM_TRIB))
        inJc = 1'b1;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.tribSel   = tribIdx;
    strobe.frameHead = (posI == 0);
    if (posI < FAW_LEN) begin
      strobe.ovBit = FAW_WORD[FAW_LEN - 1 - posI];
    end else if (posI < FAW_LEN + SVC_LEN) begin
      strobe.ovBit = 1'b1;
    end else if (inJc) begin
      strobe.ovBit = stuffLatch[tribIdx];
    end else if (posI >= STUFF_AT && posI < STUFF_AT + NUM_TRIB) begin
      if (stuffLatch[tribIdx]) strobe.ovBit = 1'b1;
      else                     strobe.takeData = 1'b1;
    end else begin
      strobe.takeData = 1'b1;
    end
  end
endmodule

// File: rtl/bitjust_dpath.sv
module bitjust_dpath
  import bitjust_pkg::*;
#(
  parameter int NUM_TRIB = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  slotStrobe_t         strobe,
  input  logic [NUM_TRIB-1:0] tribData,
  output logic [NUM_TRIB-1:0] readEn,
  output logic                serOut,
  output logic                frameStart
);
  logic nextBit;

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_re
    assign readEn[t] = rstN && strobe.takeData && (32'(strobe.tribSel) == t);
  end

  assign nextBit = strobe.takeData ? tribData[strobe.tribSel] : strobe.ovBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serOut     <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      serOut     <= nextBit;
      frameStart <= strobe.frameHead;
    end
  end
endmodule

// File: rtl/bitjust_mux.sv
module bitjust_mux
  import bitjust_pkg::*;
#(
  parameter int NUM_TRIB  = 4,
  parameter int FRAME_LEN = 848
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TRIB-1:0] tribData,
  input  logic [NUM_TRIB-1:0] stuffReq,
  output logic [NUM_TRIB-1:0] readEn,
  output logic                serOut,
  output logic                frameStart
);
  slotStrobe_t strobe;

  bitjust_ctrl #(.NUM_TRIB(NUM_TRIB), .FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .stuffReq(stuffReq), .strobe(strobe)
  );

  bitjust_dpath #(.NUM_TRIB(NUM_TRIB)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tribData(tribData),
    .readEn(readEn), .serOut(serOut), .frameStart(frameStart)
  );
endmodule

// File: rtl/bitjust_mux_chk.sv
module bitjust_mux_chk #(
  parameter int NUM_TRIB  = 4,
  parameter int FRAME_LEN = 848
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_TRIB-1:0] tribData,
  input logic [NUM_TRIB-1:0] readEn,
  input logic                serOut,
  input logic                frameStart
);
  int   gapCnt;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= 0;
      seen   <= 1'b0;
    end else if (frameStart) begin
      gapCnt <= 0;
      seen   <= 1'b1;
    end else begin
      gapCnt <= gapCnt + 1;
    end
  end

  // R7
  a_r7_one_reader: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(readEn));

  // R8
  a_r8_data_follows: assert property (@(posedge clk) disable iff (!rstN)
    (|readEn) |=> (serOut == $past(|(readEn & tribData))));

  // R9
  a_r9_frame_period: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && seen) |-> (gapCnt == FRAME_LEN - 1));

  // R9
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  // R2
  a_r2_word_leads: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> serOut);
endmodule

bind bitjust_mux bitjust_mux_chk #(.NUM_TRIB(NUM_TRIB), .FRAME_LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .tribData(tribData), .readEn(readEn),
  .serOut(serOut), .frameStart(frameStart)
);

// File: tb/sim_bitjust_mux.sv
module sim_bitjust_mux;
  localparam int FL = 848;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] tribData = '0;
  logic [3:0] stuffReq = '0;
  logic [3:0] readEn;
  logic       serOut;
  logic       frameStart;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bitjust_mux u0 (
    .clk(clk), .rstN(rstN), .tribData(tribData), .stuffReq(stuffReq),
    .readEn(readEn), .serOut(serOut), .frameStart(frameStart)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at time %0t", req, act, exp, $time);
    end
  endtask

  // behavioural slot classification: 0 data, 1 overhead
  function automatic void refSlot(input int p, input logic [3:0] st, input logic [3:0] d,
                                  output logic [3:0] re, output logic b, output string tag);
    string faw = "1111010000";
    int t = p % 4;
    re = '0;
    if (p < 10) begin
      b = (faw[p] == "1"); tag = "R2";
    end else if (p < 12) begin
      b = 1'b1; tag = "R3";
    end else if ((p >= 212 && p < 216) || (p >= 424 && p < 428) || (p >= 636 && p < 640)) begin
      b = st[t]; tag = "R4";
    end else if (p >= 640 && p < 644) begin
      tag = "R5";
      if (st[t]) b = 1'b1;
      else begin b = d[t]; re[t] = 1'b1; end
    end else begin
      b = d[t]; re[t] = 1'b1; tag = "R1";
    end
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int refPos = 0;
    logic [3:0] stL = '0;
    logic expOut = 1'b0;
    logic expFs  = 1'b0;
    string prevTag = "R10";

    // R10: reset state
    repeat (3) @(negedge clk);
    tribData = 4'hF;
    #1;
    check("R10 serOut", serOut, 0);
    check("R10 frameStart", frameStart, 0);
    check("R10 readEn", readEn, 0);

    @(negedge clk);
    rstN = 1'b1;
    for (int cyc = 0; cyc < 6 * FL; cyc++) begin
      logic [3:0] re;
      logic b;
      string tag;
      int frm = cyc / FL;
      if (cyc != 0) @(negedge clk);
      tribData = 4'($urandom);
      // R6: frame 1 all stuffed, frame 2 none, frame 3 stuffed only when sampled at p==0
      if (frm == 1)      stuffReq = 4'hF;
      else if (frm == 2) stuffReq = 4'h0;
      else if (frm == 3) stuffReq = (refPos == 0) ? 4'b0101 : 4'b1010;
      else               stuffReq = 4'($urandom);
      #1;
      // R8/R9 and overhead tags: registered output of previous slot
      check({prevTag, " serOut"}, serOut, expOut);
      check("R9 frameStart", frameStart, expFs);
      refSlot(refPos, stL, tribData, re, b, tag);
      check({"R7 readEn ", tag}, readEn, re);
      expOut  = b;
      expFs   = (refPos == 0);
      prevTag = (tag == "R1") ? "R8" : tag;
      if (refPos == 0) stL = stuffReq;
      refPos = (refPos + 1) % FL;
    end
    @(negedge clk);
    #1;
    check({prevTag, " serOut"}, serOut, expOut);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule